// File: doc/BRIEF.md
# Global-Tick Emulated Memory Write Port

This block holds a small register-array memory whose single write port belongs to a slow design clock, while every flop in the block actually runs on one fast global tick. The design clock is treated as ordinary data: it is registered on the tick, and a transition is recognised by comparing that registered copy with the live value. The write mask, address and data are also registered once on the tick. When a transition of the chosen polarity is seen, those delayed copies write the array. Between transitions the effective write mask is forced to zero.

Reads are purely combinational, and any number of read ports can be built by a parameter. A registered read port is not offered, because it would need its own clock. The block is used where a design with several clocks must be modelled on a single clock. A typical case is formal or cycle-based modelling of a write port whose clock is slower than the tick.

Top module: `tick_write_mem`

## Requirements
- R1: While reset is asserted and on the first tick after it is released, the registered design-clock copy holds the idle level: 1 when `RISING`=1, 0 when `RISING`=0. As a result, no write takes place on that first tick, even if the design clock already sits at its active level and the mask is all ones.
- R2: With `RISING`=1, a write happens on any tick at which the design clock is 1 and its registered copy is 0. That write puts the delayed data into the word at the delayed address, for every bit whose delayed mask bit is 1.
- R3: The write mask has one bit per data bit. Bits whose mask bit is 0 keep their old value, and an all-zero mask leaves the word unchanged.
- R4: While the design clock holds one level, no further write happens, whatever the mask, address and data inputs do.
- R5: With `RISING`=0, a write happens only when the design clock goes from 1 to 0. A 0-to-1 transition writes nothing.
- R6: Read data is combinational from the array. A write is visible right after the tick edge that detected the design-clock transition, and not before that edge.
- R7: The write uses the mask, address and data that were present one tick before the detecting tick. Values changed in the same tick interval as the design-clock transition do not take part in that write.
- R8: Each read port returns the word at its own address, independently of the other ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tickClk | input | 1 | Global tick; every flop in the block uses its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the edge detector |
| dsnClk | input | 1 | Design clock of the emulated write port, sampled as data |
| wrMask | input | WIDTH | Per-bit write enable |
| wrAddr | input | $clog2(DEPTH) | Write word address |
| wrData | input | WIDTH | Write data |
| rdAddr | input | NUM_RD*$clog2(DEPTH) | Packed read addresses, port p in slice p |
| rdData | output | NUM_RD*WIDTH | Packed combinational read data, port p in slice p |

## Verification
The bench builds two copies with DEPTH=16, WIDTH=8 and NUM_RD=2, one with RISING=1 and one with RISING=0. Both copies get the same stimulus, so a single design-clock waveform exercises both polarities, and a write on the wrong transition shows up as a mismatch between the two models. Sixteen words keep every address reachable within a few hundred random steps, and two read ports allow cross-port checks. Byte-wide data with random per-bit masks covers partial writes. Design-clock edges that coincide with data changes test the one-tick sampling delay.

// File: rtl/tick_write_mem_pkg.sv
package tick_write_mem_pkg;

  // Strobes passed from the edge-detect control to the array datapath.
  typedef struct packed {
    logic fire;     // design-clock transition of the selected polarity seen this tick
    logic clkLevel; // registered design-clock level
  } wr_strobe_t;

endpackage

// File: rtl/tick_write_mem_ctl.sv
module tick_write_mem_ctl
  import tick_write_mem_pkg::*;
#(
  parameter bit RISING = 1'b1
) (
  input  logic       tickClk,
  input  logic       rstN,
  input  logic       dsnClk,
  output wr_strobe_t strobe
);

  // Idle level of the registered copy: chosen so the first tick cannot fire.
  localparam logic IDLE_LVL = RISING ? 1'b1 : 1'b0;

  logic clkQ;
  logic edgeSeen;

  always_ff @(posedge tickClk or negedge rstN) begin
    if (!rstN) clkQ <= IDLE_LVL;
    else       clkQ <= dsnClk;
  end

  generate
    if (RISING) begin : g_rise
      assign edgeSeen = ~clkQ & dsnClk;
    end else begin : g_fall
      assign edgeSeen = clkQ & ~dsnClk;
    end
  endgenerate

  assign strobe.fire     = edgeSeen;
  assign strobe.clkLevel = clkQ;

endmodule

// File: rtl/tick_write_mem_dp.sv
module tick_write_mem_dp
  import tick_write_mem_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int NUM_RD = 2
) (
  input  logic                              tickClk,
  input  wr_strobe_t                        strobe,
  input  logic [WIDTH-1:0]                  wrMask,
  input  logic [$clog2(DEPTH)-1:0]          wrAddr,
  input  logic [WIDTH-1:0]                  wrData,
  input  logic [NUM_RD*$clog2(DEPTH)-1:0]   rdAddr,
  output logic [NUM_RD*WIDTH-1:0]           rdData,
  output logic [WIDTH-1:0]                  dlyMask,
  output logic [$clog2(DEPTH)-1:0]          dlyAddr
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam bit FULL_MAP = (DEPTH == (1 << ADDR_W));

  logic [WIDTH-1:0]  maskQ;
  logic [ADDR_W-1:0] addrQ;
  logic [WIDTH-1:0]  dataQ;
  logic [WIDTH-1:0]  effMask;
  logic              addrOk;
  logic [WIDTH-1:0]  memArr [DEPTH];

  // One-tick delayed copies of the write inputs.
  always_ff @(posedge tickClk) begin
    maskQ <= wrMask;
    addrQ <= wrAddr;
    dataQ <= wrData;
  end

  generate
    if (FULL_MAP) begin : g_full
      assign addrOk = 1'b1;
    end else begin : g_part
      assign addrOk = ({1'b0, addrQ} < (ADDR_W+1)'(DEPTH));
    end
  endgenerate

  assign effMask = (strobe.fire && addrOk) ? maskQ : '0;

  always_ff @(posedge tickClk) begin
    for (int b = 0; b < WIDTH; b++) begin
      if (effMask[b]) memArr[addrQ][b] <= dataQ[b];
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdData[p*WIDTH +: WIDTH] = memArr[rdAddr[p*ADDR_W +: ADDR_W]];
    end
  endgenerate

  assign dlyMask = maskQ;
  assign dlyAddr = addrQ;

endmodule

// File: rtl/tick_write_mem.sv
module tick_write_mem
  import tick_write_mem_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int NUM_RD = 2,
  parameter bit RISING = 1'b1
) (
  input  logic                            tickClk,
  input  logic                            rstN,
  input  logic                            dsnClk,
  input  logic [WIDTH-1:0]                wrMask,
  input  logic [$clog2(DEPTH)-1:0]        wrAddr,
  input  logic [WIDTH-1:0]                wrData,
  input  logic [NUM_RD*$clog2(DEPTH)-1:0] rdAddr,
  output logic [NUM_RD*WIDTH-1:0]         rdData
);

  wr_strobe_t                 strobe;
  logic [WIDTH-1:0]           dlyMask;
  logic [$clog2(DEPTH)-1:0]   dlyAddr;

  tick_write_mem_ctl #(.RISING(RISING)) u_ctl (
    .tickClk (tickClk),
    .rstN    (rstN),
    .dsnClk  (dsnClk),
    .strobe  (strobe)
  );

  tick_write_mem_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NUM_RD(NUM_RD)) u_dp (
    .tickClk (tickClk),
    .strobe  (strobe),
    .wrMask  (wrMask),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .dlyMask (dlyMask),
    .dlyAddr (dlyAddr)
  );

endmodule

// File: rtl/tick_write_mem_chk.sv
module tick_write_mem_chk #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int NUM_RD = 2,
  parameter bit RISING = 1'b1
) (
  input logic                            tickClk,
  input logic                            rstN,
  input logic                            dsnClk,
  input logic                            fire,
  input logic [WIDTH-1:0]                dlyMask,
  input logic [$clog2(DEPTH)-1:0]        dlyAddr,
  input logic [NUM_RD*$clog2(DEPTH)-1:0] rdAddr,
  input logic [NUM_RD*WIDTH-1:0]         rdData
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic ACTIVE_LVL = RISING ? 1'b1 : 1'b0;

  // R1: the first tick after reset release never writes
  a_r1_quiet_after_reset: assert property (@(posedge tickClk) disable iff (!rstN)
    $rose(rstN) |-> !fire);

  // R2 / R5: a write strobe only while the design clock sits at its active level
  a_r2_fire_at_active_level: assert property (@(posedge tickClk) disable iff (!rstN)
    fire |-> (dsnClk == ACTIVE_LVL));

  // R4: one transition gives exactly one write tick
  a_r4_single_fire: assert property (@(posedge tickClk) disable iff (!rstN)
    fire |=> !fire);

  // R3: bits outside the delayed mask keep their value on port 0
  a_r3_masked_bits_hold: assert property (@(posedge tickClk) disable iff (!rstN)
    ($past(fire) && $stable(rdAddr[ADDR_W-1:0]) && ($past(dlyAddr) == rdAddr[ADDR_W-1:0]))
      |-> (((rdData[WIDTH-1:0] ^ $past(rdData[WIDTH-1:0])) & ~$past(dlyMask)) == '0));

  // R6: read data moves only after a write tick when addresses are held
  a_r6_no_change_without_fire: assert property (@(posedge tickClk) disable iff (!rstN)
    (!$past(fire) && $stable(rdAddr)) |-> $stable(rdData));

endmodule

bind tick_write_mem tick_write_mem_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .NUM_RD(NUM_RD), .RISING(RISING)
) u_chk (
  .tickClk (tickClk),
  .rstN    (rstN),
  .dsnClk  (dsnClk),
  .fire    (strobe.fire),
  .dlyMask (dlyMask),
  .dlyAddr (dlyAddr),
  .rdAddr  (rdAddr),
  .rdData  (rdData)
);

// File: tb/tick_write_mem_tb.sv
`timescale 1ns/1ps
module tick_write_mem_tb;

  localparam int DEPTH  = 16;
  localparam int WIDTH  = 8;
  localparam int NUM_RD = 2;
  localparam int AW     = $clog2(DEPTH);

  typedef struct {
    int             inst;   // 0 rising copy, 1 falling copy
    int             port;
    logic [AW-1:0]  addr;
    logic [WIDTH-1:0] exp;
    string          req;
  } sb_item_t;

  logic tickClk = 1'b0;
  logic rstN = 1'b0;
  logic dsnClk = 1'b0;
  logic [WIDTH-1:0] wrMask = '0;
  logic [AW-1:0]    wrAddr = '0;
  logic [WIDTH-1:0] wrData = '0;
  logic [NUM_RD*AW-1:0]    rdAddr = '0;
  logic [NUM_RD*WIDTH-1:0] rdRise;
  logic [NUM_RD*WIDTH-1:0] rdFall;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] refRise [DEPTH];
  logic [WIDTH-1:0] refFall [DEPTH];
  logic             curClk = 1'b0;
  logic [WIDTH-1:0] curMask = '0;
  logic [AW-1:0]    curAddr = '0;
  logic [WIDTH-1:0] curData = '0;
  sb_item_t sbq[$];

  always #2 tickClk = ~tickClk;

  tick_write_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NUM_RD(NUM_RD), .RISING(1'b1)) u_dut (
    .tickClk(tickClk), .rstN(rstN), .dsnClk(dsnClk), .wrMask(wrMask),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdRise));

  tick_write_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NUM_RD(NUM_RD), .RISING(1'b0)) u_dutFall (
    .tickClk(tickClk), .rstN(rstN), .dsnClk(dsnClk), .wrMask(wrMask),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdFall));

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Driver: one step per global tick, changes land mid-cycle. The reference
  // models write with the values in place before this step (R7).
  task automatic step(input logic c, input logic [WIDTH-1:0] m,
                      input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge tickClk);
    if (!curClk && c)
      refRise[curAddr] = (refRise[curAddr] & ~curMask) | (curData & curMask);
    if (curClk && !c)
      refFall[curAddr] = (refFall[curAddr] & ~curMask) | (curData & curMask);
    curClk = c; curMask = m; curAddr = a; curData = d;
    dsnClk = c; wrMask = m; wrAddr = a; wrData = d;
  endtask

  task automatic push(input int inst, input int port, input logic [AW-1:0] a, input string req);
    sb_item_t it;
    it.inst = inst; it.port = port; it.addr = a;
    it.exp = inst == 0 ? refRise[a] : refFall[a];
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic drain();
    step(curClk, curMask, curAddr, curData);
    step(curClk, curMask, curAddr, curData);
    while (sbq.size() > 0) @(negedge tickClk);
  endtask

  task automatic expectAll(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      push(0, i % NUM_RD, AW'(i), req);
      push(1, (i + 1) % NUM_RD, AW'(i), req);
    end
    drain();
  endtask

  // Monitor: pops expected items and compares against the read ports.
  initial begin
    forever begin
      @(negedge tickClk);
      if (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        rdAddr[it.port*AW +: AW] = it.addr;
        #0.5;
        check(it.req, it.inst == 0 ? rdRise[it.port*WIDTH +: WIDTH]
                                   : rdFall[it.port*WIDTH +: WIDTH], it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] old;
    for (int i = 0; i < DEPTH; i++) begin refRise[i] = '0; refFall[i] = '0; end
    repeat (3) @(negedge tickClk);
    rstN = 1'b1;
    repeat (2) @(negedge tickClk);

    // R2: fill every word with a full mask, one design-clock period each
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, '1, AW'(i), WIDTH'(8'h30 + i));
      step(1'b0, '1, AW'(i), WIDTH'(8'h30 + i));
      step(1'b1, '1, AW'(i), WIDTH'(8'h30 + i));
      step(1'b1, '1, AW'(i), WIDTH'(8'h30 + i));
      step(1'b0, '1, AW'(i), WIDTH'(8'h30 + i));
    end
    step(1'b0, '0, '0, '0);
    expectAll("R2");

    // R3: partial masks, including an all-zero mask
    for (int i = 0; i < DEPTH; i++) begin
      logic [WIDTH-1:0] m;
      m = (i == 3) ? '0 : WIDTH'($urandom);
      step(1'b0, m, AW'(i), WIDTH'($urandom));
      step(1'b0, m, AW'(i), curData);
      step(1'b1, m, AW'(i), curData);
      step(1'b1, m, AW'(i), curData);
      step(1'b0, m, AW'(i), curData);
    end
    step(1'b0, '0, '0, '0);
    expectAll("R3");

    // R7: data changes in the same interval as the rising transition
    step(1'b0, '1, AW'(5), 8'hA5);
    step(1'b0, '1, AW'(5), 8'hA5);
    step(1'b1, '1, AW'(5), 8'h5A);
    step(1'b1, '0, AW'(5), 8'h5A);
    step(1'b0, '0, AW'(5), 8'h5A);
    push(0, 0, AW'(5), "R7");
    drain();
    check("R7", refRise[5], 8'hA5);

    // R4: level held high for many ticks with changing inputs
    step(1'b1, '1, AW'(6), 8'h11);
    for (int k = 0; k < 10; k++) step(1'b1, '1, AW'(k), WIDTH'($urandom));
    step(1'b1, '0, AW'(6), '0);
    step(1'b0, '0, AW'(6), '0);
    expectAll("R4");

    // R6: visible right after the detecting tick edge, not before
    step(1'b0, '1, AW'(9), 8'hC3);
    step(1'b0, '1, AW'(9), 8'hC3);
    rdAddr[1*AW +: AW] = AW'(9);
    old = refRise[9];
    step(1'b1, '0, AW'(9), 8'hC3);
    #1;
    check("R6", rdRise[1*WIDTH +: WIDTH], old);
    @(posedge tickClk);
    #1;
    check("R6", rdRise[1*WIDTH +: WIDTH], 8'hC3);
    step(1'b0, '0, AW'(9), 8'hC3);
    refRise[9] = 8'hC3;

    // R1: design clock rises inside reset; release with it already high
    step(1'b0, '0, AW'(2), 8'h00);
    step(1'b0, '0, AW'(2), 8'h00);
    @(negedge tickClk);
    rstN = 1'b0;
    wrMask = '1; wrAddr = AW'(2); wrData = 8'hEE; dsnClk = 1'b1;
    curMask = '1; curAddr = AW'(2); curData = 8'hEE; curClk = 1'b1;
    repeat (3) @(negedge tickClk);
    rstN = 1'b1;
    repeat (3) step(1'b1, '1, AW'(2), 8'hEE);
    push(0, 0, AW'(2), "R1");
    push(0, 1, AW'(2), "R1");
    drain();
    step(1'b1, '0, AW'(2), 8'hEE);
    step(1'b0, '0, AW'(2), 8'hEE);
    push(1, 0, AW'(2), "R1");
    drain();

    // R5: random slow design-clock waveform, falling copy checked too
    for (int k = 0; k < 400; k++) begin
      logic c;
      c = (($urandom % 4) == 0) ? ~curClk : curClk;
      step(c, WIDTH'($urandom), AW'($urandom), WIDTH'($urandom));
    end
    step(curClk, '0, '0, '0);
    expectAll("R5");

    // R8: two ports at different addresses in the same tick
    rdAddr[0 +: AW] = AW'(4);
    rdAddr[AW +: AW] = AW'(11);
    #1;
    check("R8", rdRise[0 +: WIDTH], refRise[4]);
    check("R8", rdRise[WIDTH +: WIDTH], refRise[11]);
    check("R8", rdFall[0 +: WIDTH], refFall[4]);
    check("R8", rdFall[WIDTH +: WIDTH], refFall[11]);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule